// File: doc/BRIEF.md
# Flag-Setting Compare and Test Unit

This block evaluates one 32-bit data-processing operation per valid strobe and keeps a four-bit status register holding negative, zero, carry and overflow indications. Operand B first passes through a shifter. The shifter moves it left or right by a five-bit amount. It then meets operand A in either an adder/subtractor or a bitwise AND/XOR stage. Four compare/test operations only update the status register. Four ordinary operations write a 32-bit result and change the status register only when their set-flags input is high.

The carry indication has two possible sources. Arithmetic operations take it from the adder. Logical operations take it from the last bit the shifter pushed out. A surrounding execution pipeline drives the operands and opcode, collects the result when the write strobe pulses, and reads the status register to decide conditional branches.

Top module: `flagcalc_unit`

## Requirements
- R1: Opcode 3'b101 (compare) sets the flags from A minus shifted B, computed as A plus the inverse of B plus one. C is the carry out of bit 31 (set means unsigned higher-or-same). V is set when the carry into bit 31 differs from the carry out of it. A=0x7FFFFFFF against B=0xFFFFFFFF with no shift gives flags 4'b1001.
- R2: Opcode 3'b100 (compare-negated) sets the flags from A plus shifted B, with C and V from the adder. A=0x7FFFFFFF against B=0xFFFFFFFF shifted left by 2 gives flags 4'b0010.
- R3: Opcode 3'b110 (test) sets N and Z from A AND shifted B. Opcode 3'b111 (test-equal) sets N and Z from A XOR shifted B, so equal operands give Z=1.
- R4: Opcodes with bit 2 set never raise `res_wr` and leave `res_out` unchanged.
- R5: Opcodes 3'b000 (add), 3'b001 (subtract), 3'b010 (AND) and 3'b011 (XOR) load `res_out` on the clock edge where `in_valid` is high. `res_wr` is high for exactly the following cycle.
- R6: The flags register `flags` = {N,Z,C,V} (bit 3 down to bit 0) changes only on an edge where `in_valid` is high and either opcode bit 2 or `set_flags` is high. Otherwise it holds.
- R7: For logical opcodes (bit 1 set), C takes the last bit shifted out of B. With a shift amount of zero, C holds its previous value. A=0x7FFFFFFF tested against B=0xFFFFFFFF shifted right by 1 gives N=0, Z=0, C=1.
- R8: For logical opcodes, V holds its previous value.
- R9: On an update, N equals bit 31 of the computed value, and Z is 1 exactly when all 32 bits are zero.
- R10: `shift_dir` 0 shifts B left and 1 shifts it right (logical, zero fill), by `shift_amt` places from 0 to 31.
- R11: A high `rst` at a clock edge clears `flags`, `res_out` and `res_wr`, and takes priority over `in_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Operation select |
| set_flags | input | 1 | Allow ordinary operations to update flags |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand, shifted before use |
| shift_dir | input | 1 | 0 left, 1 right |
| shift_amt | input | 5 | Shift distance |
| res_out | output | 32 | Registered result |
| res_wr | output | 1 | Result written on the previous edge |
| flags | output | 4 | Status register {N,Z,C,V} |

## Verification
A wrong flag bit held inside the block appears on `flags` one cycle after the operation that produced it. The bench compares against a behavioural model on every cycle, so a corrupted carry or overflow is caught at that first cycle and is not left to show up later as a bad branch. A held C or V is dangerous, because it only becomes visible when a logical operation with zero shift, or a cleared set-flags bit, should have preserved it. The stimulus therefore places such operations directly after arithmetic operations that leave C and V at known values.

// File: rtl/fcu_pkg.sv
package fcu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_EOR = 3'b011,
        OP_CMN = 3'b100,
        OP_CMP = 3'b101,
        OP_TST = 3'b110,
        OP_TEQ = 3'b111
    } fcu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } fcu_flags_t;

    function automatic logic op_is_compare(input logic [2:0] op);
        return op[2];
    endfunction

    function automatic logic op_is_logical(input logic [2:0] op);
        return op[1];
    endfunction

    // bit 0 selects subtract in the arithmetic class and XOR in the logical class
    function automatic logic op_alt(input logic [2:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/fcu_shifter.sv
module fcu_shifter #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic           dir_right,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout,
    output logic           carry,
    output logic           carry_ok
);

    logic [SHW-1:0] lsl_idx;
    logic [SHW-1:0] lsr_idx;

    // W is a power of two, so W - amt wraps to the same value as -amt
    assign lsl_idx  = SHW'(0) - amt;
    assign lsr_idx  = amt - SHW'(1);
    assign carry_ok = (amt != '0);

    always_comb begin
        if (dir_right) begin
            dout  = din >> amt;
            carry = din[lsr_idx];
        end else begin
            dout  = din << amt;
            carry = din[lsl_idx];
        end
    end

endmodule

// File: rtl/fcu_datapath.sv
module fcu_datapath #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         logical,
    input  logic         alt,
    output logic [W-1:0] value,
    output logic         add_c,
    output logic         add_v
);

    logic [W-1:0] b_eff;
    logic [W-1:0] low_sum;
    logic         c_into_msb;
    logic         msb_sum;
    logic         c_out_msb;
    logic [W-1:0] arith_val;
    logic [W-1:0] logic_val;

    assign b_eff = alt ? ~b : b;

    // lower bits summed separately to expose the carry into the top bit
    assign low_sum    = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + {{(W-1){1'b0}}, alt};
    assign c_into_msb = low_sum[W-1];
    assign msb_sum    = a[W-1] ^ b_eff[W-1] ^ c_into_msb;
    assign c_out_msb  = (a[W-1] & b_eff[W-1]) | (c_into_msb & (a[W-1] ^ b_eff[W-1]));

    assign arith_val = {msb_sum, low_sum[W-2:0]};
    assign logic_val = alt ? (a ^ b) : (a & b);

    assign value = logical ? logic_val : arith_val;
    assign add_c = c_out_msb;
    assign add_v = c_out_msb ^ c_into_msb;

endmodule

// File: rtl/flagcalc_unit.sv
module flagcalc_unit #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [2:0]     op_code,
    input  logic           set_flags,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic           shift_dir,
    input  logic [SHW-1:0] shift_amt,
    output logic [W-1:0]   res_out,
    output logic           res_wr,
    output logic [3:0]     flags
);

    import fcu_pkg::*;

    logic [W-1:0] b_shifted;
    logic         sh_carry;
    logic         sh_carry_ok;
    logic [W-1:0] value;
    logic         add_c;
    logic         add_v;
    logic         is_cmp;
    logic         is_logic;
    logic         upd_flags;
    fcu_flags_t   flags_q;
    fcu_flags_t   flags_d;

    fcu_shifter #(.W(W)) u_shift (
        .din       (opnd_b),
        .dir_right (shift_dir),
        .amt       (shift_amt),
        .dout      (b_shifted),
        .carry     (sh_carry),
        .carry_ok  (sh_carry_ok)
    );

    fcu_datapath #(.W(W)) u_dp (
        .a       (opnd_a),
        .b       (b_shifted),
        .logical (is_logic),
        .alt     (op_alt(op_code)),
        .value   (value),
        .add_c   (add_c),
        .add_v   (add_v)
    );

    assign is_cmp    = op_is_compare(op_code);
    assign is_logic  = op_is_logical(op_code);
    assign upd_flags = in_valid && (is_cmp || set_flags);

    always_comb begin
        flags_d.n = value[W-1];
        flags_d.z = (value == '0);
        if (is_logic) begin
            flags_d.c = sh_carry_ok ? sh_carry : flags_q.c;
            flags_d.v = flags_q.v;
        end else begin
            flags_d.c = add_c;
            flags_d.v = add_v;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (upd_flags) begin
            flags_q <= flags_d;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_out <= '0;
            res_wr  <= 1'b0;
        end else begin
            res_wr <= in_valid && !is_cmp;
            if (in_valid && !is_cmp) begin
                res_out <= value;
            end
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/fcu_checker.sv
module fcu_checker #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input logic           clk,
    input logic           rst,
    input logic           in_valid,
    input logic [2:0]     op_code,
    input logic           set_flags,
    input logic [SHW-1:0] shift_amt,
    input logic [W-1:0]   res_out,
    input logic           res_wr,
    input logic [3:0]     flags
);

    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[2]) |=> (!res_wr && $stable(res_out)));

    a_r5_write_pulse: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_code[2]) |=> res_wr);

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid) |=> ($stable(flags) && !res_wr));

    a_r6_no_s_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_code[2] && !set_flags) |=> $stable(flags));

    a_r7_zero_shift_c: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[1] && shift_amt == '0) |=> $stable(flags[1]));

    a_r8_logic_v_hold: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_code[1]) |=> $stable(flags[0]));

    a_r9_n_tracks_msb: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !op_code[2] && set_flags) |=> (flags[3] == res_out[W-1]
                                                   && flags[2] == (res_out == '0)));

    a_r11_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (flags == 4'b0000 && !res_wr && res_out == '0));

endmodule

bind flagcalc_unit fcu_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .set_flags (set_flags),
    .shift_amt (shift_amt),
    .res_out   (res_out),
    .res_wr    (res_wr),
    .flags     (flags)
);

// File: tb/sim_flagcalc_unit.sv
module sim_flagcalc_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  op_code;
    logic        set_flags;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        shift_dir;
    logic [4:0]  shift_amt;
    logic [31:0] res_out;
    logic        res_wr;
    logic [3:0]  flags;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [3:0]  m_flags;
    logic [31:0] m_res;
    logic        m_wr;

    always #(CLK_PERIOD/2) clk = ~clk;

    flagcalc_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_code(op_code),
        .set_flags(set_flags), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .shift_dir(shift_dir), .shift_amt(shift_amt),
        .res_out(res_out), .res_wr(res_wr), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        chk({tag, " flags"}, {28'd0, flags}, {28'd0, m_flags});
        chk({tag, " res_wr"}, {31'd0, res_wr}, {31'd0, m_wr});
        chk({tag, " res_out"}, res_out, m_res);
    endtask

    // behavioural reference: wide shifts and plain integer arithmetic
    task automatic model(input logic [2:0] o, input logic s, input logic [31:0] a,
                         input logic [31:0] b, input logic dir, input logic [4:0] amt);
        logic [63:0] t;
        logic [31:0] sb;
        logic        shc;
        logic [32:0] sum;
        logic [31:0] val;
        logic        c;
        logic        v;
        if (dir) begin
            t = {b, 32'd0} >> amt;
            sb = t[63:32];
            shc = t[31];
        end else begin
            t = {32'd0, b} << amt;
            sb = t[31:0];
            shc = t[32];
        end
        c = m_flags[1];
        v = m_flags[0];
        case (o)
            3'b000, 3'b100: begin
                sum = {1'b0, a} + {1'b0, sb};
                val = sum[31:0];
                c = sum[32];
                v = (a[31] == sb[31]) && (val[31] != a[31]);
            end
            3'b001, 3'b101: begin
                sum = {1'b0, a} + {1'b0, ~sb} + 33'd1;
                val = sum[31:0];
                c = sum[32];
                v = (a[31] != sb[31]) && (val[31] != a[31]);
            end
            3'b010, 3'b110: begin
                val = a & sb;
                if (amt != 0) c = shc;
            end
            default: begin
                val = a ^ sb;
                if (amt != 0) c = shc;
            end
        endcase
        m_wr = !o[2];
        if (!o[2]) m_res = val;
        if (o[2] || s) m_flags = {val[31], val == 32'd0, c, v};
    endtask

    task automatic run_op(input string tag, input logic [2:0] o, input logic s,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic dir, input logic [4:0] amt);
        in_valid = 1'b1; op_code = o; set_flags = s;
        opnd_a = a; opnd_b = b; shift_dir = dir; shift_amt = amt;
        @(posedge clk);
        model(o, s, a, b, dir, amt);
        @(negedge clk);
        in_valid = 1'b0;
        compare_all(tag);
    endtask

    task automatic idle(input string tag);
        @(posedge clk);
        m_wr = 1'b0;
        @(negedge clk);
        compare_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_code = 3'b000; set_flags = 1'b0;
        opnd_a = '0; opnd_b = '0; shift_dir = 1'b0; shift_amt = '0;
        m_flags = 4'b0; m_res = '0; m_wr = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        compare_all("R11 reset");
        rst = 1'b0;

        // R1 worked example: compare gives N=1 Z=0 C=0 V=1
        run_op("R1 cmp", 3'b101, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0);
        chk("R1 literal", {28'd0, flags}, 32'h9);
        // R8: logical with zero shift keeps C=0 and V=1
        run_op("R8 teq hold", 3'b111, 1'b0, 32'h1234_5678, 32'h1234_5678, 1'b0, 5'd0);
        chk("R3 teq equal Z", {28'd0, flags}, 32'h5);
        // R2 worked example
        run_op("R2 cmn", 3'b100, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd2);
        chk("R2 literal", {28'd0, flags}, 32'h2);
        // R7 worked example, precede with a V=1 result
        run_op("R1 cmp set V", 3'b101, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 5'd0);
        run_op("R7 tst", 3'b110, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'd1);
        chk("R7 literal", {28'd0, flags}, 32'h3);
        run_op("R3 teq shifted", 3'b111, 1'b0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b1, 5'd1);
        // R6: ordinary op without S keeps flags, writes result
        run_op("R6 add no S", 3'b000, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 5'd0);
        chk("R5 add result", res_out, 32'h0);
        run_op("R9 add S zero", 3'b000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, 5'd0);
        chk("R9 zero flags", {28'd0, flags}, 32'h6);
        run_op("R5 sub S", 3'b001, 1'b1, 32'h0000_0005, 32'h0000_0003, 1'b0, 5'd1);
        run_op("R5 and S lsl", 3'b010, 1'b1, 32'hF0F0_F0F0, 32'h8000_0003, 1'b0, 5'd31);
        run_op("R10 eor lsr31", 3'b011, 1'b1, 32'h0000_0000, 32'h8000_0001, 1'b1, 5'd31);
        run_op("R4 cmp after write", 3'b101, 1'b0, 32'h0000_0001, 32'h0000_0002, 1'b0, 5'd0);
        chk("R4 result kept", res_out, 32'h8000_0001 >> 31);
        idle("R6 idle");
        run_op("R10 lsl1 carry", 3'b110, 1'b0, 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 5'd1);
        chk("R10 tst lsl carry", {28'd0, flags[1]}, 32'h1);
        // sweep of arithmetic and logic under varied shifts
        for (int i = 0; i < 64; i++) begin
            logic [31:0] a;
            logic [31:0] b;
            a = 32'h9E37_79B9 * (i + 1);
            b = (32'h7F4A_7C15 ^ (i * 32'h0101_0101)) + i;
            run_op("R9 sweep", 3'(i % 8), 1'(i % 3 != 0), a, b, 1'(i % 2), 5'((i * 7) % 32));
            if (i % 5 == 0) idle("R6 sweep idle");
        end
        // R11: reset wins over a valid operation
        in_valid = 1'b1; op_code = 3'b000; set_flags = 1'b1;
        opnd_a = 32'h8000_0000; opnd_b = 32'h1; rst = 1'b1;
        @(posedge clk);
        m_flags = 4'b0; m_res = '0; m_wr = 1'b0;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        compare_all("R11 reset over valid");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule